// File: doc/BRIEF.md
# I2C Stuck-Bus Recovery Pulser

This block frees an I2C bus when a target device keeps SDA low, for example after a reset that struck in the middle of a byte. When it receives a request, it takes both bus pins away from the I2C controller through a pin-multiplexer select. It drives SCL as a push-pull output that starts high. SDA stays an input throughout, and the block has no SDA output at all.

The block then makes clock pulses until SDA reads high or a pulse budget is spent. Before each pulse it checks SDA through a synchroniser. Each pulse keeps SCL high for a timed half-period and then low for a timed half-period. When the loop ends, the pins go back to the controller in the same cycle as a one-cycle completion pulse. A result flag shows whether the bus came free. Generating a STOP condition is left to the controller.

The block has six states:
- IDLE: the pins belong to the controller.
- SEIZE: takes the pins, drives SCL high, and clears the pulse count and the result.
- PROBE: tests the synchronised SDA and the pulse count.
- HOLD_HI: SCL high for one half-period.
- HOLD_LO: SCL low for one half-period, after which the pulse count goes up.
- FINISH: pins returned, completion pulse.

The transitions are:
- IDLE→SEIZE on a request.
- SEIZE→PROBE always.
- PROBE→FINISH when SDA is high or the budget is spent.
- PROBE→HOLD_HI otherwise.
- HOLD_HI→HOLD_LO when the half-period ends.
- HOLD_LO→PROBE when the half-period ends.
- FINISH→IDLE always.

Top module: `i2c_bus_unstick`

## Requirements
- R1: During and after reset the pins belong to the controller (`pin_gpio_sel_o`=0, `scl_oe_o`=0), `scl_out_o`=1, and both `done_o` and `freed_o` are 0.
- R2: A request seen at a clock edge while idle makes `pin_gpio_sel_o`=1 (both pins), `scl_oe_o`=1 and `scl_out_o`=1 from the next cycle. SCL is driven low only while the pins are owned.
- R3: SDA passes through a `SYNC_STAGES`-flop synchroniser and is tested before every pulse. If the synchronised SDA is 1 at a test, no further pulse is made, so a bus that is already high gets zero pulses.
- R4: Each pulse holds SCL high for `HALF_CYC` cycles, then low for exactly `HALF_CYC` cycles, then returns it high for the next test.
- R5: At most `MAX_PULSES` low pulses are made per request. When the budget is spent with SDA still low, the run ends with `freed_o`=0.
- R6: At the end of a run the pins return to the controller in the same cycle that `done_o` is 1. `done_o` lasts exactly one cycle, and `freed_o`=1 exactly when SDA read 1 at the final test.
- R7: A request that arrives while a run is in progress has no effect: the run keeps its timing and produces a single `done_o`.
- R8: `freed_o` keeps its value from the completion until the next request is taken, and is cleared when the pins are seized.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_req_i | input | 1 | Recovery request, taken only while idle |
| sda_pin_i | input | 1 | Raw SDA pin level, asynchronous |
| scl_out_o | output | 1 | Level driven onto SCL while owned |
| scl_oe_o | output | 1 | Push-pull output enable for SCL |
| pin_gpio_sel_o | output | 1 | 1: both pins taken from the controller |
| done_o | output | 1 | One-cycle completion pulse |
| freed_o | output | 1 | 1 when the last run ended with SDA high |

## Verification
The target device is modelled in the bench, and it releases SDA after a chosen number of SCL falling edges. Three release settings are used:
- Already released: shows that the test comes before any pulse.
- Released after a few pulses: shows that the loop stops at the first high reading, not one pulse later, with the synchroniser delay taken into account.
- Never released: shows that the budget bound is reached and the run ends as not freed.

A second request issued in the middle of a run shows whether the request is ignored while busy. Every output is compared on every clock against a behavioural model of the timing.

// File: rtl/unstick_pkg.sv
package unstick_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SEIZE,
        ST_PROBE,
        ST_HOLD_HI,
        ST_HOLD_LO,
        ST_FINISH
    } rec_state_e;
endpackage

// File: rtl/unstick_sync.sv
module unstick_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= '1;
                else        chain <= d_i;
            end
        end else begin : g_multi
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= '1;
                else        chain <= {chain[STAGES-2:0], d_i};
            end
        end
    endgenerate

    assign q_o = chain[STAGES-1];
endmodule

// File: rtl/unstick_timer.sv
module unstick_timer #(
    parameter int LEN = 500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    output logic zero_o
);
    localparam int W = (LEN < 2) ? 1 : $clog2(LEN);
    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           cnt <= '0;
        else if (load_i)      cnt <= W'(LEN - 1);
        else if (cnt != '0)   cnt <= cnt - 1'b1;
    end

    assign zero_o = (cnt == '0);
endmodule

// File: rtl/unstick_pulse_cnt.sv
module unstick_pulse_cnt #(
    parameter int LIMIT = 100,
    localparam int W = $clog2(LIMIT + 1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    input  logic         inc_i,
    output logic [W-1:0] count_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     count_o <= '0;
        else if (clr_i) count_o <= '0;
        else if (inc_i) count_o <= count_o + 1'b1;
    end
endmodule

// File: rtl/i2c_bus_unstick.sv
module i2c_bus_unstick
    import unstick_pkg::*;
#(
    parameter int HALF_CYC    = 500,
    parameter int MAX_PULSES  = 100,
    parameter int SYNC_STAGES = 2,
    localparam int CNT_W      = $clog2(MAX_PULSES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_req_i,
    input  logic sda_pin_i,
    output logic scl_out_o,
    output logic scl_oe_o,
    output logic pin_gpio_sel_o,
    output logic done_o,
    output logic freed_o
);
    rec_state_e       state, state_nx;
    logic             sda_s;
    logic             tmr_zero;
    logic             tmr_load;
    logic             pulse_inc;
    logic [CNT_W-1:0] pulse_cnt;
    logic             at_limit;

    unstick_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_i(sda_pin_i), .q_o(sda_s)
    );

    unstick_timer #(.LEN(HALF_CYC)) u_timer (
        .clk(clk), .rst_n(rst_n), .load_i(tmr_load), .zero_o(tmr_zero)
    );

    unstick_pulse_cnt #(.LIMIT(MAX_PULSES)) u_pcnt (
        .clk(clk), .rst_n(rst_n), .clr_i(state == ST_SEIZE),
        .inc_i(pulse_inc), .count_o(pulse_cnt)
    );

    assign at_limit  = (pulse_cnt == CNT_W'(MAX_PULSES));
    assign pulse_inc = (state == ST_HOLD_LO) && tmr_zero;
    assign tmr_load  = ((state == ST_PROBE) && !sda_s && !at_limit) ||
                       ((state == ST_HOLD_HI) && tmr_zero);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:    if (start_req_i) state_nx = ST_SEIZE;
            ST_SEIZE:   state_nx = ST_PROBE;
            ST_PROBE:   if (sda_s || at_limit) state_nx = ST_FINISH;
                        else                   state_nx = ST_HOLD_HI;
            ST_HOLD_HI: if (tmr_zero) state_nx = ST_HOLD_LO;
            ST_HOLD_LO: if (tmr_zero) state_nx = ST_PROBE;
            ST_FINISH:  state_nx = ST_IDLE;
            default:    state_nx = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        pin_gpio_sel_o = 1'b0;
        scl_oe_o       = 1'b0;
        scl_out_o      = 1'b1;
        done_o         = 1'b0;
        unique case (state)
            ST_IDLE:    ;
            ST_SEIZE,
            ST_PROBE,
            ST_HOLD_HI: begin
                pin_gpio_sel_o = 1'b1;
                scl_oe_o       = 1'b1;
            end
            ST_HOLD_LO: begin
                pin_gpio_sel_o = 1'b1;
                scl_oe_o       = 1'b1;
                scl_out_o      = 1'b0;
            end
            ST_FINISH:  done_o = 1'b1;
            default:    ;
        endcase
    end

    // result flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                    freed_o <= 1'b0;
        else if (state == ST_SEIZE)                    freed_o <= 1'b0;
        else if ((state == ST_PROBE) && (sda_s || at_limit)) freed_o <= sda_s;
    end
endmodule

// File: rtl/unstick_checker.sv
module unstick_checker #(
    parameter int HALF_CYC   = 500,
    parameter int MAX_PULSES = 100,
    localparam int CNT_W     = $clog2(MAX_PULSES + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_req_i,
    input logic             scl_out_o,
    input logic             scl_oe_o,
    input logic             pin_gpio_sel_o,
    input logic             done_o,
    input logic             freed_o,
    input logic [CNT_W-1:0] pulse_cnt
);
    logic [31:0] low_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         low_run <= '0;
        else if (scl_out_o) low_run <= '0;
        else                low_run <= low_run + 1;
    end

    AST_SEIZE_ON_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (!pin_gpio_sel_o && !done_o && start_req_i) |=> (pin_gpio_sel_o && scl_oe_o && scl_out_o)); // R2
    AST_LOW_ONLY_OWNED: assert property (@(posedge clk) disable iff (!rst_n)
        !scl_out_o |-> (pin_gpio_sel_o && scl_oe_o)); // R2
    AST_LOW_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(scl_out_o) |-> (low_run == 32'(HALF_CYC))); // R4
    AST_PULSE_BUDGET: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_cnt <= CNT_W'(MAX_PULSES)); // R5
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R6
    AST_DONE_PINS_BACK: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!pin_gpio_sel_o && !scl_oe_o)); // R6
    AST_FREED_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> $stable(freed_o)); // R8
endmodule

bind i2c_bus_unstick unstick_checker #(
    .HALF_CYC(HALF_CYC), .MAX_PULSES(MAX_PULSES)
) u_chk (
    .clk(clk), .rst_n(rst_n), .start_req_i(start_req_i),
    .scl_out_o(scl_out_o), .scl_oe_o(scl_oe_o),
    .pin_gpio_sel_o(pin_gpio_sel_o), .done_o(done_o),
    .freed_o(freed_o), .pulse_cnt(pulse_cnt)
);

// File: tb/i2c_bus_unstick_tb.sv
`timescale 1ns/1ps
module i2c_bus_unstick_tb;
    localparam int HALF = 4;
    localparam int MAXP = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req = 1'b0;
    logic sda = 1'b1;
    logic scl_out, scl_oe, sel, done, freed;

    int n_checks = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    i2c_bus_unstick #(.HALF_CYC(HALF), .MAX_PULSES(MAXP), .SYNC_STAGES(2)) u_dut (
        .clk(clk), .rst_n(rst_n), .start_req_i(req), .sda_pin_i(sda),
        .scl_out_o(scl_out), .scl_oe_o(scl_oe), .pin_gpio_sel_o(sel),
        .done_o(done), .freed_o(freed)
    );

    // behavioural reference: phase 0 idle,1 grab,2 test,3 high,4 low,5 end
    int ph = 0, tc = 0, pulses = 0;
    bit m_freed = 0, s1 = 1, s2 = 1;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ph = 0; tc = 0; pulses = 0; m_freed = 0; s1 = 1; s2 = 1;
        end else begin
            case (ph)
                0: if (req) ph = 1;
                1: begin ph = 2; pulses = 0; m_freed = 0; end
                2: if (s2) begin m_freed = 1; ph = 5; end
                   else if (pulses >= MAXP) begin m_freed = 0; ph = 5; end
                   else begin ph = 3; tc = 0; end
                3: begin tc++; if (tc == HALF) begin ph = 4; tc = 0; end end
                4: begin tc++; if (tc == HALF) begin pulses++; ph = 2; end end
                default: ph = 0;
            endcase
            s2 = s1; s1 = sda;
        end
    end

    task automatic check(input string tag, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0b expected %0b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic check_int(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic report;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    endtask

    int falls = 0, dones = 0, rel_after = 0;
    logic prev_scl = 1'b1;

    // one cycle: compare at the falling edge, then drive inputs
    task automatic tick;
        @(negedge clk);
        check("R2 pin select", sel, (ph >= 1 && ph <= 4));
        check("R2 scl enable", scl_oe, (ph >= 1 && ph <= 4));
        check("R4 scl level", scl_out, (ph != 4));
        check("R6 done", done, (ph == 5));
        check("R8 freed", freed, m_freed);
        if (prev_scl && !scl_out) falls++;
        prev_scl = scl_out;
        if (done) dones++;
        sda = (falls >= rel_after);
        req = 1'b0;
    endtask

    task automatic run(input int rel, input bit poke, input int exp_pulses, input bit exp_freed);
        falls = 0; dones = 0; rel_after = rel;
        sda = (rel == 0);
        repeat (3) tick();
        req = 1'b1;
        for (int i = 0; i < 400; i++) begin
            tick();
            if (poke && i == 10) req = 1'b1;   // R7 request mid-run
            if (dones > 0) break;
        end
        check("R6 freed at end", freed, exp_freed);
        repeat (6) tick();
        check_int("R7 single completion", dones, 1);
        if (exp_pulses == MAXP) check_int("R5 budget pulses", falls, exp_pulses);
        else                    check_int("R3 pulses before release", falls, exp_pulses);
        sda = 1'b1; rel_after = 0;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not finish");
        report();
        $finish;
    end

    initial begin
        @(negedge clk);
        check("R1 reset select", sel, 1'b0);
        check("R1 reset enable", scl_oe, 1'b0);
        check("R1 reset scl", scl_out, 1'b1);
        check("R1 reset done", done, 1'b0);
        check("R1 reset freed", freed, 1'b0);
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        run(0, 1'b0, 0, 1'b1);      // R3 already free
        run(3, 1'b0, 3, 1'b1);      // R3 release after three pulses
        run(99, 1'b0, MAXP, 1'b0);  // R5 never released
        run(2, 1'b1, 2, 1'b1);      // R7 poke while busy
        run(1, 1'b0, 1, 1'b1);      // R8 freed cleared then set again
        report();
        $finish;
    end
endmodule